// File: doc/BRIEF.md
# Two-Line Grouped Interrupt Controller

This block turns a set of single-bit event inputs into two interrupt request lines. Each input has a sticky status flag. The flag is set on a rising edge of the input and stays set until software clears it by writing a one to it. A per-flag enable mask decides which flags may raise an interrupt. The flags are split into seven fixed classes. One select bit per class sends that class to line 0 or to line 1, and a separate enable bit per line gates each output.

Software reaches four registers through a simple single-cycle write strobe and a combinational read port. The flags stay visible for polling even when their interrupt is masked.

Top module: `irq_two_line_ctrl`

## Requirements
- R1: A flag is set in the cycle after a 0-to-1 transition of its event input is seen. An input that stays high does not set the flag again after it has been cleared.
- R2: Writing to register 0 clears every flag whose write-data bit is 1. Flags whose write-data bit is 0 are left unchanged, and no flag falls without such a write.
- R3: When an event rises in the same cycle as a write-one-to-clear of its own flag, the flag ends up set.
- R4: A flag only counts toward an interrupt when its bit in the enable register (register 1) is 1. With no enabled flag set, both lines are low in the next cycle.
- R5: Flags belong to classes by index: 0-2 class 0, 3-5 class 1, 6-9 class 2, 10-12 class 3, 13-16 class 4, 17-20 class 5, 21-23 class 6. Class k uses bit k of the route register (register 2).
- R6: A route bit of 0 sends its class to line 0 (irq_o[0]). A route bit of 1 sends it to line 1 (irq_o[1]).
- R7: Bit 0 of register 3 enables line 0 and bit 1 enables line 1. A line whose enable bit is 0 stays low.
- R8: Each line is a register. It goes high one cycle after the enabled flag that causes it is set.
- R9: Reset clears the flags, the enable, route and line-enable registers, the edge history and both lines.
- R10: Reads of registers 0 to 3 return the flags, the enable mask, the route bits and the line enables. Unused upper bits read as zero.
- R11: Flags keep latching events while their enable or line enable is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_i | input | 24 | Event inputs, one per flag |
| wr_en_i | input | 1 | Single-cycle write strobe |
| addr_i | input | 2 | Register select: 0 flags, 1 enable, 2 route, 3 line enable |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 2 | Interrupt lines 0 and 1 |

## Verification
The assertions check on every cycle that:
- a seen rising edge always leaves its flag set, so set wins over clear;
- no flag drops without a write to the flag register;
- a disabled line never rises;
- neither line is high in the cycle after no enabled flag is set.

Only the bench scenarios can show:
- that the class boundaries map each flag to the right route bit;
- that a route bit picks the intended line;
- the one-cycle output latency;
- that a held-high input does not set its flag again;
- the register read-back widths.

// File: rtl/irq_two_line_ctrl.sv
module irq_two_line_ctrl #(
  parameter int N_SRC  = 24,
  parameter int N_GRP  = 7,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  ev_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [1:0]        irq_o
);
  localparam logic [ADDR_W-1:0] A_FLAG  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_EN    = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_ROUTE = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_LEN   = ADDR_W'(3);

  function automatic int grp_of(input int i);
    if (i < 3)       return 0;
    else if (i < 6)  return 1;
    else if (i < 10) return 2;
    else if (i < 13) return 3;
    else if (i < 17) return 4;
    else if (i < 21) return 5;
    else             return N_GRP - 1;
  endfunction

  logic [N_SRC-1:0] ev_q, flag_q, en_q, rise, clr, act, on_l1;
  logic [N_GRP-1:0] route_q;
  logic [1:0]       len_q, hit, irq_q;
  logic             wr_flag;

  assign wr_flag = wr_en_i && (addr_i == A_FLAG);
  assign rise    = ev_i & ~ev_q;
  assign clr     = wr_flag ? wdata_i[N_SRC-1:0] : '0;
  assign act     = flag_q & en_q;

  always_comb begin
    for (int i = 0; i < N_SRC; i++) on_l1[i] = route_q[grp_of(i)];
  end

  assign hit[0] = (|(act & ~on_l1)) & len_q[0];
  assign hit[1] = (|(act &  on_l1)) & len_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q    <= '0;
      flag_q  <= '0;
      en_q    <= '0;
      route_q <= '0;
      len_q   <= '0;
      irq_q   <= '0;
    end else begin
      ev_q   <= ev_i;
      flag_q <= (flag_q & ~clr) | rise;
      irq_q  <= hit;
      if (wr_en_i && addr_i == A_EN)    en_q    <= wdata_i[N_SRC-1:0];
      if (wr_en_i && addr_i == A_ROUTE) route_q <= wdata_i[N_GRP-1:0];
      if (wr_en_i && addr_i == A_LEN)   len_q   <= wdata_i[1:0];
    end
  end

  always_comb begin
    case (addr_i)
      A_FLAG:  rdata_o = DATA_W'(flag_q);
      A_EN:    rdata_o = DATA_W'(en_q);
      A_ROUTE: rdata_o = DATA_W'(route_q);
      default: rdata_o = DATA_W'(len_q);
    endcase
  end

  assign irq_o = irq_q;

  AST_SET_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((flag_q & $past(rise)) == $past(rise)));           // R1 R3
  AST_CLEAR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_flag |=> ((flag_q & $past(flag_q)) == $past(flag_q)));       // R2
  AST_IDLE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(flag_q & en_q)) |=> (irq_o == 2'b00));                       // R4
  AST_LINE0_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !len_q[0] |=> !irq_o[0]);                                        // R7
  AST_LINE1_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !len_q[1] |=> !irq_o[1]);                                        // R7
endmodule

// File: tb/test_irq_two_line_ctrl.sv
`timescale 1ns/1ps
module test_irq_two_line_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] ev = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  irq;
  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  irq_two_line_ctrl i_irq_two_line_ctrl (
    .clk(clk), .rst_n(rst_n), .ev_i(ev), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  always #2.5 clk = ~clk;

  // {event[58:35], enable[34:11], route[10:4], line_en[3:2], expected irq[1:0]}
  localparam logic [58:0] VEC [10] = '{
    {24'h000001, 24'h000001, 7'h00, 2'b11, 2'b01},
    {24'h000001, 24'h000001, 7'h01, 2'b11, 2'b10},
    {24'h000001, 24'h000000, 7'h00, 2'b11, 2'b00},
    {24'h800000, 24'hFFFFFF, 7'h40, 2'b01, 2'b00},
    {24'h800000, 24'hFFFFFF, 7'h40, 2'b10, 2'b10},
    {24'h000440, 24'hFFFFFF, 7'h04, 2'b11, 2'b11},
    {24'h010000, 24'hFFFFFF, 7'h08, 2'b11, 2'b01},
    {24'h020000, 24'hFFFFFF, 7'h10, 2'b11, 2'b01},
    {24'h000008, 24'hFFFFFF, 7'h01, 2'b11, 2'b01},
    {24'h000200, 24'hFFFFFF, 7'h04, 2'b11, 2'b10}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a; #0.5; d = rdata;
  endtask

  task automatic pulse(input logic [23:0] p);
    @(negedge clk); ev = p;
    @(negedge clk); ev = '0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    check("R9 irq in reset", 32'(irq), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd0, r); check("R9 flags after reset", r, 32'h0);
    rd(2'd1, r); check("R9 enable after reset", r, 32'h0);
    rd(2'd3, r); check("R9 line enable after reset", r, 32'h0);

    for (int k = 0; k < 10; k++) begin
      wr(2'd0, 32'hFFFFFFFF);
      wr(2'd1, 32'(VEC[k][34:11]));
      wr(2'd2, 32'(VEC[k][10:4]));
      wr(2'd3, 32'(VEC[k][3:2]));
      pulse(VEC[k][58:35]);
      @(negedge clk);
      check($sformatf("R4 R5 R6 R7 vector %0d irq", k), 32'(irq), 32'(VEC[k][1:0]));
      rd(2'd0, r);
      check($sformatf("R1 R11 vector %0d flags", k), r, 32'(VEC[k][58:35]));
    end

    // R8: one-cycle latency from flag to line
    wr(2'd0, 32'hFFFFFFFF); wr(2'd1, 32'h00FFFFFF); wr(2'd2, 32'h0); wr(2'd3, 32'h3);
    @(negedge clk);
    pulse(24'h000001);
    check("R8 irq low in flag-set cycle", 32'(irq), 32'h0);
    rd(2'd0, r); check("R8 flag already set", r, 32'h1);
    @(negedge clk);
    check("R8 irq high one cycle later", 32'(irq), 32'h1);

    // R2: writing zeros has no effect, ones clear selected bits
    wr(2'd0, 32'hFFFFFFFF);
    pulse(24'h000003);
    wr(2'd0, 32'h0);
    rd(2'd0, r); check("R2 zero write keeps flags", r, 32'h3);
    wr(2'd0, 32'h1);
    rd(2'd0, r); check("R2 one write clears only bit0", r, 32'h2);

    // R3: set wins over clear in the same cycle
    wr(2'd0, 32'hFFFFFFFF);
    @(negedge clk); wr_en = 1'b1; addr = 2'd0; wdata = 32'h20; ev = 24'h000020;
    @(negedge clk); wr_en = 1'b0;
    rd(2'd0, r); check("R3 set beats clear", r, 32'h20);
    // R1: held input does not re-set after clear
    wr(2'd0, 32'h20);
    repeat (2) @(negedge clk);
    rd(2'd0, r); check("R1 held high no re-set", r, 32'h0);
    ev = '0;

    // R10: read-back widths
    wr(2'd1, 32'hFFFFFFFF); rd(2'd1, r); check("R10 enable width", r, 32'h00FFFFFF);
    wr(2'd2, 32'hFFFFFFFF); rd(2'd2, r); check("R10 route width", r, 32'h7F);
    wr(2'd3, 32'hFFFFFFFF); rd(2'd3, r); check("R10 line enable width", r, 32'h3);

    // R9: reset mid-run clears state
    pulse(24'h000100);
    @(negedge clk);
    check("R9 irq before reset", 32'(irq), 32'h2);
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 irq cleared", 32'(irq), 32'h0);
    rd(2'd0, r); check("R9 flags cleared", r, 32'h0);
    rd(2'd2, r); check("R9 route cleared", r, 32'h0);
    rst_n = 1'b1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule